// File: doc/BRIEF.md
# Two-Rate Serial Avionics Word Receiver

This block takes one return-to-zero serial line presented as two digital levels: one level high means a one is being sent, the other high means a zero, and both low is the null state between bits and words. Each master-clock cycle is one sample. The rate control selects a nominal bit cell of 10 samples (fast) or 80 samples (slow). The block finds word boundaries from the null gap. It decides each bit by vote, packs 32 or 25 bits into a word, and can drop words whose two address bits do not match a programmed code. It records a parity status with each word and keeps the accepted word for a host.

The host sees an active-low ready flag. It reads the kept word as two 16-bit halves through a half-select input and an active-low read enable. For self-test, the serial stream of a local transmitter can replace the line input. A build parameter lets one instance take that stream with ones and zeros swapped, so a second receiver sees the complement.

Top module: `a429_rx`

## Requirements
- R1: With `rate_slow`=0 the bit cell is FAST_DIV (10) samples; with `rate_slow`=1 it is SLOW_DIV (80) samples. In the slow mode, words with cells of 69 to 111 samples are received correctly.
- R2: A cell whose first part shows `line_a` high carries a one, and one that shows `line_b` high carries a zero. Serial bit n (bit 1 sent first) is stored at word bit n-1.
- R3: With `len_short`=0 a word has 32 bits. With `len_short`=1 it has 25 bits, and word bits 31:25 read as zero. The length is captured when each word starts, so a change during a word applies from the next word.
- R4: With `filt_en`=1, word bit 8 must equal `filt_x` and word bit 9 must equal `filt_y`. A word that fails this is dropped: `rdy_n` does not fall and the kept word does not change.
- R5: `rdy_n` falls when a word is accepted and never falls otherwise.
- R6: With `rd_n`=0, `rd_data` shows word bits 15:0 when `half_sel`=0 and bits 31:16 when `half_sel`=1. With `rd_n`=1 it is zero.
- R7: Each clock edge with `rd_n`=0 marks the selected half as read. `rdy_n` returns high once both halves are marked, and it stays low while they are not. A new accepted word replaces an unread one.
- R8: A word starts only at a null-to-data change that follows at least one full bit cell of null. A word whose bits stop before the selected length is dropped. Bits that follow a completed word with no such gap are ignored.
- R9: Each bit is the majority of the one-samples against the zero-samples over the first half cell after its null-to-data change, so a minority of wrong samples does not change it. Timing re-aligns at every bit.
- R10: `par_even` is 1 when the kept word holds an even number of ones, which marks an odd-parity error.
- R11: With `wrap_en`=1 the receiver decodes `wrap_a`/`wrap_b` and ignores the line. With WRAP_INVERT=1 the ones and zeros of that stream are exchanged, so the kept word is the bitwise complement.
- R12: `rst_n`=0 sets `rdy_n` high and clears the bit, word and gap state. After reset, a word needs a full null cell before it can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a | input | 1 | Line level meaning "one" |
| line_b | input | 1 | Line level meaning "zero" |
| wrap_en | input | 1 | Take the self-test stream instead of the line |
| wrap_a | input | 1 | Self-test stream "one" level |
| wrap_b | input | 1 | Self-test stream "zero" level |
| rate_slow | input | 1 | 0: 10-sample cell, 1: 80-sample cell |
| len_short | input | 1 | 0: 32-bit word, 1: 25-bit word |
| filt_en | input | 1 | Enable the address-bit match |
| filt_x | input | 1 | Required value of word bit 8 |
| filt_y | input | 1 | Required value of word bit 9 |
| half_sel | input | 1 | 0: low half, 1: high half |
| rd_n | input | 1 | Active-low read enable |
| rd_data | output | WORD_W/2 | Selected half of the kept word |
| rdy_n | output | 1 | Active-low word-waiting flag |
| par_even | output | 1 | Kept word has an even count of ones |

## Verification
A line level passes one input register, and the vote ends half a cell after the final bit's first data sample. Two more registers follow, so `rdy_n` and the kept word change half a cell plus three cycles after that sample. The bench waits several null cells after each word before it looks, so no check falls inside that latency. Read marking takes effect at the edge inside the low pulse of `rd_n`, and the bench samples `rdy_n` at the next falling edge. `rd_data` is combinational, so it is sampled 1 ns after `rd_n` falls.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  // Two-level line sample: hi = "one" level, lo = "zero" level, both 0 = null.
  typedef struct packed {
    logic hi;
    logic lo;
  } line_t;
endpackage

// File: rtl/a429_rx_front.sv
module a429_rx_front
  import a429_rx_pkg::*;
#(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_DIV    = 80,
  parameter bit WRAP_INVERT = 1'b0
) (
  input  logic  clk,
  input  logic  arst_n,
  input  line_t line_in,
  input  line_t wrap_in,
  input  logic  wrap_en,
  input  logic  slow,
  output line_t smp,
  output logic  start,
  output logic  gap_ok
);
  localparam int CNT_W = $clog2(SLOW_DIV + 1);

  line_t             wrap_src;
  line_t             pick;
  logic              act;
  logic              act_q;
  logic [CNT_W-1:0]  bit_len;
  logic [CNT_W-1:0]  gap_q;
  logic [CNT_W-1:0]  gap_d;

  generate
    if (WRAP_INVERT) begin : g_wrap_swap
      assign wrap_src.hi = wrap_in.lo;
      assign wrap_src.lo = wrap_in.hi;
    end else begin : g_wrap_thru
      assign wrap_src = wrap_in;
    end
  endgenerate

  assign pick    = wrap_en ? wrap_src : line_in;
  assign bit_len = slow ? CNT_W'(SLOW_DIV) : CNT_W'(FAST_DIV);
  assign act     = smp.hi | smp.lo;

  always_comb begin
    gap_d = gap_q;
    if (act)                  gap_d = '0;
    else if (gap_q < bit_len) gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      smp   <= '0;
      act_q <= 1'b0;
      gap_q <= '0;
    end else begin
      smp   <= pick;
      act_q <= act;
      gap_q <= gap_d;
    end
  end

  assign start  = act & ~act_q;
  assign gap_ok = (gap_q >= bit_len);
endmodule

// File: rtl/a429_rx_vote.sv
module a429_rx_vote
  import a429_rx_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic  clk,
  input  logic  arst_n,
  input  line_t smp,
  input  logic  start,
  input  logic  slow,
  output logic  bit_done,
  output logic  bit_val
);
  localparam int CNT_W = $clog2(SLOW_DIV + 1);

  logic [CNT_W-1:0] half_len;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ones_q, ones_d;
  logic [CNT_W-1:0] zeros_q, zeros_d;

  assign half_len = slow ? CNT_W'(SLOW_DIV / 2) : CNT_W'(FAST_DIV / 2);
  assign bit_done = busy_q && (cnt_q == half_len);
  assign bit_val  = ones_q > zeros_q;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    ones_d  = ones_q;
    zeros_d = zeros_q;
    if (start) begin
      busy_d  = 1'b1;
      cnt_d   = CNT_W'(1);
      ones_d  = CNT_W'(smp.hi);
      zeros_d = CNT_W'(smp.lo);
    end else if (busy_q) begin
      if (bit_done) begin
        busy_d = 1'b0;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        ones_d  = ones_q + CNT_W'(smp.hi);
        zeros_d = zeros_q + CNT_W'(smp.lo);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      ones_q  <= '0;
      zeros_q <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      ones_q  <= ones_d;
      zeros_q <= zeros_d;
    end
  end
endmodule

// File: rtl/a429_rx_assemble.sv
module a429_rx_assemble #(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 25
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              start,
  input  logic              gap_ok,
  input  logic              cfg_short,
  input  logic              bit_done,
  input  logic              bit_val,
  input  logic              filt_en,
  input  logic              filt_x,
  input  logic              filt_y,
  output logic              acc_vld,
  output logic [WORD_W-1:0] acc_word,
  output logic              acc_par
);
  localparam int IDX_W = $clog2(WORD_W + 1);
  localparam int XPOS  = 8;
  localparam int YPOS  = 9;

  logic              in_q, in_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              short_q, short_d;
  logic [WORD_W-1:0] full;
  logic [IDX_W-1:0]  len;
  logic              last;
  logic              match;
  logic              take;

  always_comb begin
    full = sh_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (IDX_W'(i) == idx_q) full[i] = bit_val;
    end
  end

  assign len   = short_q ? IDX_W'(SHORT_W) : IDX_W'(WORD_W);
  assign last  = bit_done && in_q && (idx_q + IDX_W'(1) == len);
  assign match = !filt_en || ((full[XPOS] == filt_x) && (full[YPOS] == filt_y));
  assign take  = last && match;

  always_comb begin
    in_d    = in_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    short_d = short_q;
    if (start && gap_ok) begin
      in_d    = 1'b1;
      idx_d   = '0;
      sh_d    = '0;
      short_d = cfg_short;
    end else if (gap_ok && in_q) begin
      in_d = 1'b0;
    end else if (bit_done && in_q) begin
      sh_d  = full;
      idx_d = idx_q + 1'b1;
      if (last) in_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      short_q  <= 1'b0;
      acc_vld  <= 1'b0;
      acc_word <= '0;
      acc_par  <= 1'b0;
    end else begin
      in_q    <= in_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      short_q <= short_d;
      acc_vld <= take;
      if (take) begin
        acc_word <= full;
        acc_par  <= ~^full;
      end
    end
  end
endmodule

// File: rtl/a429_rx_hold.sv
module a429_rx_hold #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                acc_vld,
  input  logic [WORD_W-1:0]   acc_word,
  input  logic                acc_par,
  input  logic                half_sel,
  input  logic                rd_n,
  output logic                rdy_n,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                par_even,
  output logic [WORD_W-1:0]   held_word
);
  localparam int HALF_W = WORD_W / 2;

  logic              rdy_q, rdy_d;
  logic              lo_q, lo_d;
  logic              hi_q, hi_d;
  logic [WORD_W-1:0] held_q;
  logic              par_q;

  always_comb begin
    rdy_d = rdy_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    if (acc_vld) begin
      rdy_d = 1'b1;
      lo_d  = 1'b0;
      hi_d  = 1'b0;
    end else if (rdy_q && !rd_n) begin
      lo_d = lo_q | ~half_sel;
      hi_d = hi_q | half_sel;
      if (lo_d && hi_d) begin
        rdy_d = 1'b0;
        lo_d  = 1'b0;
        hi_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdy_q  <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      held_q <= '0;
      par_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      if (acc_vld) begin
        held_q <= acc_word;
        par_q  <= acc_par;
      end
    end
  end

  assign rdy_n     = ~rdy_q;
  assign par_even  = par_q;
  assign held_word = held_q;
  assign rd_data   = rd_n ? '0 : (half_sel ? held_q[WORD_W-1:HALF_W] : held_q[HALF_W-1:0]);
endmodule

// File: rtl/a429_rx.sv
module a429_rx
  import a429_rx_pkg::*;
#(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_DIV    = 80,
  parameter int WORD_W      = 32,
  parameter int SHORT_W     = 25,
  parameter bit WRAP_INVERT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_a,
  input  logic                line_b,
  input  logic                wrap_en,
  input  logic                wrap_a,
  input  logic                wrap_b,
  input  logic                rate_slow,
  input  logic                len_short,
  input  logic                filt_en,
  input  logic                filt_x,
  input  logic                filt_y,
  input  logic                half_sel,
  input  logic                rd_n,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                rdy_n,
  output logic                par_even
);
  logic [1:0]        rsync_q;
  logic              arst_n;
  line_t             line_in;
  line_t             wrap_in;
  line_t             smp;
  logic              start;
  logic              gap_ok;
  logic              bit_done;
  logic              bit_val;
  logic              acc_vld;
  logic [WORD_W-1:0] acc_word;
  logic              acc_par;
  logic [WORD_W-1:0] held_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  assign line_in.hi = line_a;
  assign line_in.lo = line_b;
  assign wrap_in.hi = wrap_a;
  assign wrap_in.lo = wrap_b;

  a429_rx_front #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .WRAP_INVERT(WRAP_INVERT)) u_front (
    .clk(clk), .arst_n(arst_n), .line_in(line_in), .wrap_in(wrap_in), .wrap_en(wrap_en),
    .slow(rate_slow), .smp(smp), .start(start), .gap_ok(gap_ok)
  );

  a429_rx_vote #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_vote (
    .clk(clk), .arst_n(arst_n), .smp(smp), .start(start), .slow(rate_slow),
    .bit_done(bit_done), .bit_val(bit_val)
  );

  a429_rx_assemble #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_asm (
    .clk(clk), .arst_n(arst_n), .start(start), .gap_ok(gap_ok), .cfg_short(len_short),
    .bit_done(bit_done), .bit_val(bit_val), .filt_en(filt_en), .filt_x(filt_x), .filt_y(filt_y),
    .acc_vld(acc_vld), .acc_word(acc_word), .acc_par(acc_par)
  );

  a429_rx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .arst_n(arst_n), .acc_vld(acc_vld), .acc_word(acc_word), .acc_par(acc_par),
    .half_sel(half_sel), .rd_n(rd_n), .rdy_n(rdy_n), .rd_data(rd_data), .par_even(par_even),
    .held_word(held_word)
  );
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_n,
  input logic              rd_n,
  input logic              filt_en,
  input logic              filt_x,
  input logic              filt_y,
  input logic              acc_vld,
  input logic              acc_x,
  input logic              acc_y,
  input logic              bit_done,
  input logic [WORD_W-1:0] held_word
);
  // R5: an accepted word lowers the ready flag on the next edge
  assert_ready_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> !rdy_n);

  // R5: without an accepted word the flag never falls
  assert_ready_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_n && !acc_vld) |=> rdy_n);

  // R7: with no read and no new word a waiting flag stays low
  assert_ready_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && rd_n && !acc_vld) |=> !rdy_n);

  // R7: the kept word changes only through an accepted word
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(held_word));

  // R4: an accepted word passed the address-bit match when it was enabled
  assert_filter_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && $past(filt_en)) |-> ((acc_x == $past(filt_x)) && (acc_y == $past(filt_y))));

  // R9: one decision per vote window
  assert_vote_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
endmodule

bind a429_rx a429_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .rd_n(rd_n), .filt_en(filt_en),
  .filt_x(filt_x), .filt_y(filt_y), .acc_vld(acc_vld), .acc_x(acc_word[8]),
  .acc_y(acc_word[9]), .bit_done(bit_done), .held_word(held_word)
);

// File: tb/tb_a429_rx.sv
module tb_a429_rx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, line_a, line_b, wrap_en, wrap_a, wrap_b;
  logic rate_slow, len_short, filt_en, filt_x, filt_y, half_sel, rd_n;
  logic [15:0] rd_data, rd_data2;
  logic rdy_n, rdy2_n, par_even, par2;
  int total = 0;
  int bad = 0;

  a429_rx dut (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b), .wrap_en(wrap_en),
    .wrap_a(wrap_a), .wrap_b(wrap_b), .rate_slow(rate_slow), .len_short(len_short),
    .filt_en(filt_en), .filt_x(filt_x), .filt_y(filt_y), .half_sel(half_sel), .rd_n(rd_n),
    .rd_data(rd_data), .rdy_n(rdy_n), .par_even(par_even)
  );

  a429_rx #(.WRAP_INVERT(1'b1)) dut2 (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b), .wrap_en(wrap_en),
    .wrap_a(wrap_a), .wrap_b(wrap_b), .rate_slow(rate_slow), .len_short(len_short),
    .filt_en(filt_en), .filt_x(filt_x), .filt_y(filt_y), .half_sel(half_sel), .rd_n(rd_n),
    .rd_data(rd_data2), .rdy_n(rdy2_n), .par_even(par2)
  );

  typedef struct packed {
    logic [31:0] w;
    logic        slow;
    logic        shrt;
    logic        fen;
    logic        fx;
    logic        fy;
    logic        acc;
    logic [7:0]  per;
    logic [7:0]  dat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'hA5A53C0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10,  8'd5},
    '{32'h00000001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10,  8'd5},
    '{32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10,  8'd5},
    '{32'h12345678, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd69,  8'd34},
    '{32'h00000100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd10,  8'd5},
    '{32'h00000200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10,  8'd5},
    '{32'h00000300, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd10,  8'd5},
    '{32'h0C0FFEE5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd111, 8'd55},
    '{32'hC3C3C3C3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd80,  8'd40}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit: index of a bit whose first two data samples show the opposite level
  task automatic send_bits(input logic [63:0] w, input int nbits, input int per, input int dat,
                           input bit to_wrap, input int glitch_bit);
    logic h, l;
    for (int i = 0; i < nbits; i++) begin
      for (int s = 0; s < per; s++) begin
        @(negedge clk);
        if (s < dat) begin
          h = w[i];
          l = !w[i];
          if (i == glitch_bit && s < 2) begin
            h = !w[i];
            l = w[i];
          end
        end else begin
          h = 1'b0;
          l = 1'b0;
        end
        if (to_wrap) begin
          wrap_a = h; wrap_b = l;
        end else begin
          line_a = h; line_b = l;
        end
      end
    end
    @(negedge clk);
    line_a = 1'b0; line_b = 1'b0; wrap_a = 1'b0; wrap_b = 1'b0;
  endtask

  task automatic read_half(input logic sel, output logic [15:0] d, output logic [15:0] d2);
    @(negedge clk);
    half_sel = sel;
    rd_n = 1'b0;
    #1;
    d = rd_data;
    d2 = rd_data2;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic read_word(output logic [31:0] w, output logic [31:0] w2);
    logic [15:0] lo, hi, lo2, hi2;
    read_half(1'b0, lo, lo2);
    read_half(1'b1, hi, hi2);
    w = {hi, lo};
    w2 = {hi2, lo2};
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got, got2, expw, prev;
    logic [15:0] h16, h16b;
    rst_n = 1'b0; line_a = 1'b0; line_b = 1'b0; wrap_en = 1'b0; wrap_a = 1'b0; wrap_b = 1'b0;
    rate_slow = 1'b0; len_short = 1'b0; filt_en = 1'b0; filt_x = 1'b0; filt_y = 1'b0;
    half_sel = 1'b0; rd_n = 1'b1;
    idle(5);
    check("R12", "ready in reset", {31'd0, rdy_n}, 32'd1);
    rst_n = 1'b1;
    idle(5);
    check("R12", "ready after reset", {31'd0, rdy_n}, 32'd1);
    check("R6", "bus idle when not enabled", {16'd0, rd_data}, 32'd0);
    idle(20);

    // table of vectors
    prev = 32'd0;
    for (int v = 0; v < NV; v++) begin
      rate_slow = VECS[v].slow;
      len_short = VECS[v].shrt;
      filt_en = VECS[v].fen;
      filt_x = VECS[v].fx;
      filt_y = VECS[v].fy;
      idle(2 * int'(VECS[v].per));
      send_bits({32'd0, VECS[v].w}, VECS[v].shrt ? 25 : 32, int'(VECS[v].per),
                int'(VECS[v].dat), 1'b0, -1);
      idle(4 * int'(VECS[v].per));
      check(VECS[v].shrt ? "R3" : (VECS[v].fen ? "R4" : "R1"), "ready after word",
            {31'd0, rdy_n}, {31'd0, !VECS[v].acc});
      expw = VECS[v].shrt ? (VECS[v].w & 32'h01FFFFFF) : VECS[v].w;
      if (!VECS[v].acc) expw = prev;
      read_word(got, got2);
      check(VECS[v].fen ? "R4" : "R2", "word read", got, expw);
      check("R10", "parity status", {31'd0, par_even},
            {31'd0, ($countones(expw) % 2) == 0});
      check("R7", "ready high after both halves", {31'd0, rdy_n}, 32'd1);
      prev = expw;
    end
    rate_slow = 1'b0; len_short = 1'b0; filt_en = 1'b0;
    idle(30);

    // R7: overwrite before read
    send_bits({32'd0, 32'h11111111}, 32, 10, 5, 1'b0, -1);
    idle(40);
    send_bits({32'd0, 32'h22222222}, 32, 10, 5, 1'b0, -1);
    idle(40);
    read_word(got, got2);
    check("R7", "newer word replaces unread one", got, 32'h22222222);

    // R7: single half read keeps ready low
    send_bits({32'd0, 32'h33333333}, 32, 10, 5, 1'b0, -1);
    idle(40);
    read_half(1'b0, h16, h16b);
    check("R6", "low half", {16'd0, h16}, 32'h00003333);
    check("R7", "ready after one half", {31'd0, rdy_n}, 32'd0);
    read_half(1'b1, h16, h16b);
    check("R6", "high half", {16'd0, h16}, 32'h00003333);
    check("R7", "ready after second half", {31'd0, rdy_n}, 32'd1);

    // R3: length change during a word applies to the next word only
    fork
      send_bits({32'd0, 32'h44444444}, 32, 10, 5, 1'b0, -1);
      begin idle(60); len_short = 1'b1; end
    join
    idle(40);
    read_word(got, got2);
    check("R3", "length captured at word start", got, 32'h44444444);
    len_short = 1'b0;
    idle(20);

    // R8: truncated word is dropped
    send_bits({32'd0, 32'h66666666}, 20, 10, 5, 1'b0, -1);
    idle(40);
    check("R8", "truncated word gives no ready", {31'd0, rdy_n}, 32'd1);

    // R8: bits following a full word without a gap are ignored
    send_bits({32'h0BADF00D, 32'h77777777}, 64, 10, 5, 1'b0, -1);
    idle(40);
    check("R8", "first word of gapless stream ready", {31'd0, rdy_n}, 32'd0);
    read_word(got, got2);
    check("R8", "gapless stream keeps first word", got, 32'h77777777);
    idle(20);
    check("R8", "trailing bits raise no ready", {31'd0, rdy_n}, 32'd1);

    // R9: minority of wrong samples in a one bit and in a zero bit
    send_bits({32'd0, 32'h18181818}, 32, 10, 5, 1'b0, 3);
    idle(40);
    read_word(got, got2);
    check("R9", "vote keeps a one bit", got, 32'h18181818);
    send_bits({32'd0, 32'h18181818}, 32, 10, 5, 1'b0, 0);
    idle(40);
    read_word(got, got2);
    check("R9", "vote keeps a zero bit", got, 32'h18181818);

    // R11: self-test stream replaces the line
    wrap_en = 1'b1;
    idle(20);
    send_bits({32'd0, 32'h99999999}, 32, 10, 5, 1'b0, -1);
    idle(40);
    check("R11", "line ignored in self-test", {31'd0, rdy_n}, 32'd1);
    send_bits({32'd0, 32'h5A5A0F0F}, 32, 10, 5, 1'b1, -1);
    idle(40);
    read_word(got, got2);
    check("R11", "self-test word", got, 32'h5A5A0F0F);
    check("R11", "inverted self-test word", got2, 32'hA5A5F0F0);
    wrap_en = 1'b0;
    idle(20);

    // R12: reset drops a waiting word and a word in flight
    send_bits({32'd0, 32'h13579BDF}, 32, 10, 5, 1'b0, -1);
    idle(40);
    check("R5", "ready before reset", {31'd0, rdy_n}, 32'd0);
    fork
      send_bits({32'd0, 32'h7E7E7E7E}, 32, 10, 5, 1'b0, -1);
      begin
        idle(100);
        rst_n = 1'b0;
        idle(1);
        check("R12", "ready high in reset", {31'd0, rdy_n}, 32'd1);
        idle(2);
        rst_n = 1'b1;
      end
    join
    idle(40);
    check("R12", "no word after mid-word reset", {31'd0, rdy_n}, 32'd1);

    summary();
    $finish;
  end
endmodule